// File: doc/BRIEF.md
# GF(4096) Syndrome Calculator

This block computes eight Reed-Solomon syndromes over a stream of 12-bit symbols, one symbol per clock. Each field element is handled as a pair of 6-bit halves over GF(64). GF(64) reduces by x^6+x+1. A quadratic extension over GF(64) gives the full 12-bit field.

Every syndrome has its own accumulator with a fixed root. Each accepted symbol updates the accumulator by Horner's rule. The roots form a chain: the first root is 1, and each next root is the previous one times 0xE01.

When the symbol flagged as last is accepted, the block latches all eight results. They are packed two per 32-bit word, and a flag is raised if any syndrome is nonzero. The results then stay unchanged until the next codeword ends. A decoder downstream reads the packed words and uses the nonzero flag to decide whether correction is needed. With eight syndromes, up to four symbol errors can be corrected.

Top module: `gf4096_syndrome_calc`

## Requirements
- R1: While reset is high and after it is released, `synd_valid` and `synd_nonzero` are 0 and all of `synd_words` is 0.
- R2: Syndrome k uses root r_k, where r_0 = 1 and r_(k+1) = r_k·0xE01. The successor of 0 is defined as 1.
- R3: Field products split each operand into h = bits 11:6 and l = bits 5:0. The product's high half is (ah^al)·(bh^bl) ^ al·bl. Its low half is ah·bh·0x21 ^ al·bl. Each GF(64) product reduces modulo x^6+x+1, so an overflow into bit 6 is removed by XOR with 0x43.
- R4: For each accepted symbol d, each accumulator becomes S·r_k ^ d. The first symbol of a codeword starts from S = 0. Syndrome k of symbols d_0..d_(n-1) is therefore the XOR of d_j·r_k^(n-1-j).
- R5: `synd_valid` is high for exactly the one cycle after the clock edge that accepts a symbol with `sym_last` high.
- R6: Output word m carries syndrome 2m in bits 11:0 and syndrome 2m+1 in bits 27:16. Bits 15:12 and 31:28 are always 0. Word m occupies `synd_words[32m+31:32m]`.
- R7: `synd_nonzero` is updated together with the syndromes. It is 1 exactly when at least one latched syndrome is nonzero.
- R8: In cycles with `sym_valid` low, `sym_data` has no effect on any result.
- R9: `sym_last` is ignored while `sym_valid` is low. It neither ends a codeword nor updates the outputs.
- R10: The outputs hold their values until the next codeword ends. The symbol after a last symbol starts a new codeword.
- R11: For a one-symbol codeword of value d, every syndrome equals d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | A symbol is present on `sym_data` this cycle |
| sym_last | input | 1 | The present symbol ends the codeword |
| sym_data | input | 12 | Symbol value |
| synd_valid | output | 1 | One-cycle pulse when new syndromes are latched |
| synd_words | output | 128 | Four packed words, two syndromes in each |
| synd_nonzero | output | 1 | At least one latched syndrome is nonzero |

## Verification
The embedded properties check these points on every cycle:
- the timing of the result pulse after each accepted last symbol;
- that results hold between codeword ends;
- that the spare bits of each packed word stay zero;
- that the nonzero flag agrees with the latched syndromes;
- that each accumulator loads the first symbol of a codeword;
- that each accumulator holds in idle cycles.

The arithmetic itself can only be shown by the bench scenarios. This covers the composite-field multiplier, the chain of roots, and the Horner evaluation. The bench compares against a power-sum model built from an independent polynomial-reduction multiplier. It uses single-symbol codewords, root-exposing pairs, all-zero data, back-to-back codewords, and random streams in which idle cycles carry junk data and stray last flags.

// File: rtl/synd_pkg.sv
package synd_pkg;
  localparam int SYM_W  = 12;
  localparam int HALF_W = SYM_W / 2;
  localparam int WORD_W = 32;
  localparam int SLOT_W = WORD_W / 2;
  localparam logic [HALF_W-1:0] EXT_CONST = 6'h21;
  localparam logic [SYM_W-1:0]  STEP_MUL  = 12'hE01;

  // shift-and-add over GF(64), reducing x^6 -> x+1
  function automatic logic [HALF_W-1:0] gf64_mul_f(input logic [HALF_W-1:0] a,
                                                   input logic [HALF_W-1:0] b);
    logic [HALF_W-1:0] aa;
    logic [HALF_W:0]   bb;
    logic [HALF_W-1:0] c;
    aa = a;
    bb = {1'b0, b};
    c  = '0;
    for (int i = 0; i < HALF_W; i++) begin
      if (aa[0]) c = c ^ bb[HALF_W-1:0];
      aa = aa >> 1;
      bb = bb << 1;
      if (bb[HALF_W]) bb = bb ^ 7'h43;
    end
    return c;
  endfunction

  function automatic logic [SYM_W-1:0] gf4096_mul_f(input logic [SYM_W-1:0] a,
                                                    input logic [SYM_W-1:0] b);
    logic [HALF_W-1:0] hi, lo, ll;
    ll = gf64_mul_f(a[HALF_W-1:0], b[HALF_W-1:0]);
    hi = gf64_mul_f(a[SYM_W-1:HALF_W] ^ a[HALF_W-1:0],
                    b[SYM_W-1:HALF_W] ^ b[HALF_W-1:0]) ^ ll;
    lo = gf64_mul_f(gf64_mul_f(a[SYM_W-1:HALF_W], b[SYM_W-1:HALF_W]), EXT_CONST) ^ ll;
    return {hi, lo};
  endfunction

  // root k of the successor chain that starts at 1
  function automatic logic [SYM_W-1:0] root_of(input int k);
    logic [SYM_W-1:0] r;
    r = 12'd1;
    for (int i = 0; i < k; i++)
      r = (r == '0) ? 12'd1 : gf4096_mul_f(r, STEP_MUL);
    return r;
  endfunction
endpackage

// File: rtl/gf64_mult.sv
module gf64_mult (
  input  logic [synd_pkg::HALF_W-1:0] a,
  input  logic [synd_pkg::HALF_W-1:0] b,
  output logic [synd_pkg::HALF_W-1:0] p
);
  localparam int HW = synd_pkg::HALF_W;

  logic [HW-1:0] aa;
  logic [HW:0]   bb;
  logic [HW-1:0] acc;

  always_comb begin
    aa  = a;
    bb  = {1'b0, b};
    acc = '0;
    for (int i = 0; i < HW; i++) begin
      if (aa[0]) acc = acc ^ bb[HW-1:0];
      aa = aa >> 1;
      bb = bb << 1;
      if (bb[HW]) bb = bb ^ 7'h43;
    end
  end

  assign p = acc;
endmodule

// File: rtl/gf4096_mult.sv
module gf4096_mult (
  input  logic [synd_pkg::SYM_W-1:0] a,
  input  logic [synd_pkg::SYM_W-1:0] b,
  output logic [synd_pkg::SYM_W-1:0] p
);
  localparam int SW = synd_pkg::SYM_W;
  localparam int HW = synd_pkg::HALF_W;

  logic [HW-1:0] a_hi, a_lo, b_hi, b_lo;
  logic [HW-1:0] cross_p, low_p, high_p, scaled_p;

  assign a_hi = a[SW-1:HW];
  assign a_lo = a[HW-1:0];
  assign b_hi = b[SW-1:HW];
  assign b_lo = b[HW-1:0];

  gf64_mult u_cross (.a(a_hi ^ a_lo), .b(b_hi ^ b_lo),        .p(cross_p));
  gf64_mult u_low   (.a(a_lo),        .b(b_lo),               .p(low_p));
  gf64_mult u_high  (.a(a_hi),        .b(b_hi),               .p(high_p));
  gf64_mult u_scale (.a(high_p),      .b(synd_pkg::EXT_CONST), .p(scaled_p));

  assign p = {cross_p ^ low_p, scaled_p ^ low_p};
endmodule

// File: rtl/synd_cell.sv
module synd_cell #(
  parameter logic [synd_pkg::SYM_W-1:0] ROOT = 12'd1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       shift_en,
  input  logic                       restart,
  input  logic [synd_pkg::SYM_W-1:0] sym,
  output logic [synd_pkg::SYM_W-1:0] acc_q,
  output logic [synd_pkg::SYM_W-1:0] acc_d
);
  localparam int SW = synd_pkg::SYM_W;

  logic [SW-1:0] scaled;

  gf4096_mult u_mul (.a(acc_q), .b(ROOT), .p(scaled));

  assign acc_d = (restart ? '0 : scaled) ^ sym;

  always_ff @(posedge clk) begin
    if (rst)           acc_q <= '0;
    else if (shift_en) acc_q <= acc_d;
  end

  // R4
  first_sym_load_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_en && restart) |=> (acc_q == $past(sym)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(acc_q));
endmodule

// File: rtl/gf4096_syndrome_calc.sv
module gf4096_syndrome_calc #(
  parameter int NSYND = 8
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         sym_valid,
  input  logic                                         sym_last,
  input  logic [synd_pkg::SYM_W-1:0]                   sym_data,
  output logic                                         synd_valid,
  output logic [(NSYND/2)*synd_pkg::WORD_W-1:0]        synd_words,
  output logic                                         synd_nonzero
);
  localparam int SW    = synd_pkg::SYM_W;
  localparam int WW    = synd_pkg::WORD_W;
  localparam int SLOT  = synd_pkg::SLOT_W;
  localparam int NWORD = NSYND / 2;
  localparam int OUT_W = NWORD * WW;

  function automatic logic [OUT_W-1:0] used_mask();
    logic [OUT_W-1:0] m;
    m = '0;
    for (int k = 0; k < NSYND; k++)
      m[(k/2)*WW + (k%2)*SLOT +: SW] = '1;
    return m;
  endfunction
  localparam logic [OUT_W-1:0] USED = used_mask();

  logic          fresh_q;
  logic          accept_last;
  logic          any_nz;
  logic [SW-1:0] acc_q [NSYND];
  logic [SW-1:0] acc_d [NSYND];

  assign accept_last = sym_valid && sym_last;

  // next symbol begins a codeword
  always_ff @(posedge clk) begin
    if (rst)            fresh_q <= 1'b1;
    else if (sym_valid) fresh_q <= sym_last;
  end

  for (genvar k = 0; k < NSYND; k++) begin : g_cell
    localparam logic [SW-1:0] RK = synd_pkg::root_of(k);
    synd_cell #(.ROOT(RK)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .shift_en (sym_valid),
      .restart  (fresh_q),
      .sym      (sym_data),
      .acc_q    (acc_q[k]),
      .acc_d    (acc_d[k])
    );
  end

  always_comb begin
    any_nz = 1'b0;
    for (int k = 0; k < NSYND; k++)
      any_nz = any_nz | (acc_d[k] != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      synd_valid   <= 1'b0;
      synd_words   <= '0;
      synd_nonzero <= 1'b0;
    end else begin
      synd_valid <= accept_last;
      if (accept_last) begin
        for (int k = 0; k < NSYND; k++)
          synd_words[(k/2)*WW + (k%2)*SLOT +: SW] <= acc_d[k];
        synd_nonzero <= any_nz;
      end
    end
  end

  // R5
  pulse_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    accept_last |=> synd_valid);
  // R9
  no_pulse_without_last_chk: assert property (@(posedge clk) disable iff (rst)
    !accept_last |=> !synd_valid);
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !synd_valid |-> ($stable(synd_words) && $stable(synd_nonzero)));
  // R6
  spare_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (synd_words & ~USED) == '0);
  // R7
  nonzero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    synd_nonzero == (synd_words != '0));
endmodule

// File: tb/test_gf4096_syndrome_calc.sv
module test_gf4096_syndrome_calc;
  localparam int NS = 8;
  localparam int NW = NS / 2;
  localparam int MAXLEN = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sym_valid = 1'b0;
  logic sym_last = 1'b0;
  logic [11:0] sym_data = '0;
  logic synd_valid;
  logic [NW*32-1:0] synd_words;
  logic synd_nonzero;

  gf4096_syndrome_calc #(.NSYND(NS)) i_gf4096_syndrome_calc (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_last(sym_last),
    .sym_data(sym_data), .synd_valid(synd_valid), .synd_words(synd_words),
    .synd_nonzero(synd_nonzero));

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [11:0] cw [MAXLEN];
  int n = 0;
  logic [11:0] roots [NS];
  logic [NW*32-1:0] exp_words = '0;
  logic exp_nz = 1'b0;
  bit pending = 1'b0;
  string cw_tag = "R4";

  // polynomial product followed by reduction by x^6+x+1
  function automatic logic [5:0] m64(input logic [5:0] a, input logic [5:0] b);
    logic [10:0] p;
    p = '0;
    for (int i = 0; i < 6; i++) if (b[i]) p = p ^ (11'(a) << i);
    for (int k = 10; k >= 6; k--) if (p[k]) p = p ^ (11'h43 << (k - 6));
    return p[5:0];
  endfunction

  function automatic logic [11:0] m4096(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] ah, al, bh, bl;
    ah = a[11:6]; al = a[5:0]; bh = b[11:6]; bl = b[5:0];
    return {m64(ah ^ al, bh ^ bl) ^ m64(al, bl), m64(m64(ah, bh), 6'h21) ^ m64(al, bl)};
  endfunction

  function automatic logic [11:0] gpow(input logic [11:0] r, input int e);
    logic [11:0] x;
    x = 12'd1;
    for (int i = 0; i < e; i++) x = m4096(x, r);
    return x;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_cw();
    logic [11:0] s;
    exp_words = '0;
    exp_nz = 1'b0;
    for (int k = 0; k < NS; k++) begin
      s = '0;
      for (int j = 0; j < n; j++) s = s ^ m4096(cw[j], gpow(roots[k], n - 1 - j));
      exp_words[(k/2)*32 + (k%2)*16 +: 12] = s;
      if (s != '0) exp_nz = 1'b1;
    end
    n = 0;
  endtask

  // one clock: drive, model, sample at the following falling edge
  task automatic step(input bit v, input logic [11:0] d, input bit l);
    sym_valid = v; sym_data = d; sym_last = l;
    @(posedge clk);
    pending = 1'b0;
    if (v) begin
      cw[n] = d;
      n++;
      if (l) begin
        finish_cw();
        pending = 1'b1;
      end
    end
    @(negedge clk);
    chk(l && !v ? "R9" : "R5", 64'(synd_valid), 64'(pending));
    if (pending) begin
      for (int k = 0; k < NS; k++)
        chk(cw_tag, 64'(synd_words[(k/2)*32 + (k%2)*16 +: 12]),
                    64'(exp_words[(k/2)*32 + (k%2)*16 +: 12]));
      for (int m = 0; m < NW; m++) begin
        chk("R6", 64'(synd_words[m*32+12 +: 4]), 64'd0);
        chk("R6", 64'(synd_words[m*32+28 +: 4]), 64'd0);
      end
      chk("R7", 64'(synd_nonzero), 64'(exp_nz));
    end else begin
      chk(v ? "R10" : "R8", 64'(synd_words), 64'(exp_words));
      chk("R10", 64'(synd_nonzero), 64'(exp_nz));
    end
  endtask

  task automatic idle_junk();
    step(1'b0, 12'($urandom), 1'($urandom));
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R2: independent chain of roots
    roots[0] = 12'd1;
    for (int k = 1; k < NS; k++)
      roots[k] = (roots[k-1] == '0) ? 12'd1 : m4096(roots[k-1], 12'hE01);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", 64'(synd_valid), 64'd0);
    chk("R1", 64'(synd_words), 64'd0);
    chk("R1", 64'(synd_nonzero), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", 64'(synd_words), 64'd0);

    // R11: single symbol codewords, back to back
    cw_tag = "R11";
    step(1'b1, 12'hABC, 1'b1);
    step(1'b1, 12'h001, 1'b1);
    step(1'b1, 12'hFFF, 1'b1);

    // R2: pair [1,0] exposes each root
    cw_tag = "R2";
    step(1'b1, 12'h001, 1'b0);
    step(1'b1, 12'h000, 1'b1);

    // R3: pair [a,0] gives a times each root
    cw_tag = "R3";
    step(1'b1, 12'hFC3, 1'b0);
    step(1'b1, 12'h000, 1'b1);
    step(1'b1, 12'h7E5, 1'b0);
    step(1'b1, 12'h000, 1'b1);

    // R7: all-zero codeword clears the flag
    cw_tag = "R7";
    for (int i = 0; i < 5; i++) step(1'b1, 12'h000, i == 4);

    // R9: stray last flags in idle cycles
    cw_tag = "R9";
    step(1'b1, 12'h123, 1'b0);
    step(1'b0, 12'hFFF, 1'b1);
    step(1'b0, 12'h5A5, 1'b1);
    step(1'b1, 12'h456, 1'b1);

    // R4 / R8 / R10: random codewords with junk-filled gaps
    cw_tag = "R4";
    for (int c = 0; c < 60; c++) begin
      int len;
      len = 1 + int'($urandom % 40);
      for (int i = 0; i < len; i++) begin
        if ($urandom % 4 == 0) idle_junk();
        step(1'b1, 12'($urandom), i == len - 1);
      end
      repeat ($urandom % 3) idle_junk();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule